// File: doc/BRIEF.md
# Write-Protected Seconds Clock

A memory-mapped real-time clock that counts whole seconds in a 32-bit register. It advances on a one-pulse-per-second tick while its run bit is set, and compares the count against a programmable alarm value. Two sticky event flags record the per-second tick and the alarm match. Each flag can drive a shared interrupt line through its own enable.

Software reaches the block through a request/response register bus. The request side has a valid/ready pair, but ready is always high, so the block never applies back-pressure. A read returns its data one cycle after acceptance, marked by a response-valid strobe, and the response has no back-pressure of its own. Writes are guarded twice. After an accepted write, a busy window of several slow-clock enables blocks further writes, and the write-ready bit in the control register reads low during it. In the protected build, every write must also be armed first by writing the key 0x0000A55A to the key register. A scratch register has no reset, so software can use it to tell whether state was lost.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset, control (offset 0x00) reads 0x80, seconds (0x04) reads 0, regulator (0x0C) reads 0, and irq is low.
- R2: Seconds advance by one on each tick cycle only while control bit0 (run) is 1; with run at 0 a tick leaves the count unchanged.
- R3: Control bit7 (write-ready) falls after an accepted write and rises again after BUSY_SLOW slow-clock enables. A write made while it is low is ignored.
- R4: Writing 0x0000A55A to the key register (0x3C) makes it read 0x80000000 (bit31). Writes to other registers are ignored while bit31 is 0, and bit31 clears after one accepted write. An ignored write leaves bit31 set.
- R5: Control bit6 (second flag) sets on every tick, whatever the run bit holds.
- R6: For control bit6 and bit4 (alarm flag), writing 0 clears the flag and writing 1 leaves it as it was. Bits 5, 3, 2 and 0 are plain read/write.
- R7: The alarm flag sets when control bit2 (alarm enable) is 1 and the seconds count becomes equal to the alarm register (0x08). With bit2 at 0, no flag is set.
- R8: irq is high exactly when (bit6 and bit5) or (bit4 and bit3).
- R9: The scratch register (0x34) keeps its written value through a reset.
- R10: The regulator register (0x0C) stores and returns a full 32-bit value.
- R11: req_ready is always 1. A read returns its data with rsp_valid in the next cycle. The seconds value is captured whole, so consecutive reads with no tick between them match.
- R12: A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_ce | input | 1 | One-cycle enable per slow-clock period |
| tick_1hz | input | 1 | One-cycle pulse per second |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes while the busy window is still open and writes without the key. A design that ignored either guard would let the seconds register change. It checks that the key bit clears after a write is taken and survives one that is dropped, and that a design that never cleared it would read 0x80000000 where 0 is due. It writes ones and zeros to the sticky flags, since a plain register would wrongly set a flag from a written 1. It steps the count into the alarm value with the alarm disabled, checks that a scratch value survives a reset that clears everything else, and ticks with the run bit low to catch a counter that ignores run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_SEC   = 'h04;
  localparam int unsigned OFS_ALARM = 'h08;
  localparam int unsigned OFS_REG   = 'h0C;
  localparam int unsigned OFS_SCR   = 'h34;
  localparam int unsigned OFS_KEY   = 'h3C;

  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_AEN   = 2;
  localparam int unsigned B_AIE   = 3;
  localparam int unsigned B_AFLG  = 4;
  localparam int unsigned B_SIE   = 5;
  localparam int unsigned B_SFLG  = 6;
  localparam int unsigned B_WRDY  = 7;

  localparam logic [31:0] KEY_VALUE = 32'h0000_A55A;
endpackage

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate #(
  parameter int unsigned BUSY_SLOW = 4,
  parameter bit          PROTECT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_ce,
  input  logic wr_req,
  input  logic key_wr,
  output logic wr_ok,
  output logic wrdy,
  output logic unlocked
);
  localparam int unsigned CW = $clog2(BUSY_SLOW + 1);
  localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_SLOW);

  logic [CW-1:0] busy_cnt;

  assign wrdy = (busy_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      busy_cnt <= '0;
    else if (wr_ok)
      busy_cnt <= BUSY_LOAD;
    else if (slow_ce && busy_cnt != '0)
      busy_cnt <= busy_cnt - 1'b1;
  end

  generate
    if (PROTECT) begin : g_key
      logic arm_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          arm_q <= 1'b0;
        else if (wr_ok)
          arm_q <= 1'b0;
        else if (key_wr)
          arm_q <= 1'b1;
      end
      assign unlocked = arm_q;
      assign wr_ok    = wr_req && wrdy && arm_q;
    end else begin : g_open
      logic unused_key;
      assign unused_key = key_wr;
      assign unlocked   = 1'b0;
      assign wr_ok      = wr_req && wrdy;
    end
  endgenerate
endmodule

// File: rtl/rtc_sec_count.sv
module rtc_sec_count #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] sec
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      sec <= '0;
    else if (load)
      sec <= load_val;
    else if (tick && run)
      sec <= sec + 1'b1;
  end
endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] sec,
  input  logic [W-1:0] alarm,
  input  logic         al_en,
  input  logic         ctrl_wr,
  input  logic         keep_sflg,
  input  logic         keep_aflg,
  output logic         sec_flag,
  output logic         al_flag
);
  logic match, match_q, al_hit;

  assign match  = al_en && (sec == alarm);
  assign al_hit = match && !match_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q  <= 1'b0;
      sec_flag <= 1'b0;
      al_flag  <= 1'b0;
    end else begin
      match_q <= match;
      if (tick)
        sec_flag <= 1'b1;
      else if (ctrl_wr && !keep_sflg)
        sec_flag <= 1'b0;
      if (al_hit)
        al_flag <= 1'b1;
      else if (ctrl_wr && !keep_aflg)
        al_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BUSY_SLOW = 4,
  parameter bit          PROTECT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_ce,
  input  logic              tick_1hz,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(OFS_SEC);
  localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(OFS_ALARM);
  localparam logic [ADDR_W-1:0] A_REG   = ADDR_W'(OFS_REG);
  localparam logic [ADDR_W-1:0] A_SCR   = ADDR_W'(OFS_SCR);
  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);

  logic        wr_cyc, rd_cyc, mapped, key_wr, wr_ok, wrdy, unlocked;
  logic        sec_load, ctrl_wr;
  logic        run_q, sie_q, aie_q, al_en_q;
  logic        sec_flag, al_flag;
  logic [31:0] sec_q, alarm_q, regu_q, scr_q, rd_mux, ctrl_view;

  assign req_ready = 1'b1;
  assign wr_cyc    = req_valid && req_write;
  assign rd_cyc    = req_valid && !req_write;
  assign mapped    = (req_addr == A_CTRL) || (req_addr == A_SEC) ||
                     (req_addr == A_ALARM) || (req_addr == A_REG) ||
                     (req_addr == A_SCR);
  assign key_wr    = wr_cyc && (req_addr == A_KEY) && (req_wdata == KEY_VALUE);
  assign sec_load  = wr_ok && (req_addr == A_SEC);
  assign ctrl_wr   = wr_ok && (req_addr == A_CTRL);

  rtc_wr_gate #(.BUSY_SLOW(BUSY_SLOW), .PROTECT(PROTECT)) u_gate (
    .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce),
    .wr_req(wr_cyc && mapped), .key_wr(key_wr),
    .wr_ok(wr_ok), .wrdy(wrdy), .unlocked(unlocked)
  );

  rtc_sec_count #(.W(32)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .run(run_q),
    .load(sec_load), .load_val(req_wdata), .sec(sec_q)
  );

  rtc_event_flags #(.W(32)) u_flags (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .sec(sec_q),
    .alarm(alarm_q), .al_en(al_en_q), .ctrl_wr(ctrl_wr),
    .keep_sflg(req_wdata[B_SFLG]), .keep_aflg(req_wdata[B_AFLG]),
    .sec_flag(sec_flag), .al_flag(al_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      sie_q   <= 1'b0;
      aie_q   <= 1'b0;
      al_en_q <= 1'b0;
      alarm_q <= '0;
      regu_q  <= '0;
    end else if (wr_ok) begin
      case (req_addr)
        A_CTRL: begin
          run_q   <= req_wdata[B_RUN];
          sie_q   <= req_wdata[B_SIE];
          aie_q   <= req_wdata[B_AIE];
          al_en_q <= req_wdata[B_AEN];
        end
        A_ALARM: alarm_q <= req_wdata;
        A_REG:   regu_q  <= req_wdata;
        default: ;
      endcase
    end
  end

  // Scratch storage deliberately has no reset.
  always_ff @(posedge clk) begin
    if (wr_ok && req_addr == A_SCR)
      scr_q <= req_wdata;
  end

  always_comb begin
    ctrl_view         = '0;
    ctrl_view[B_WRDY] = wrdy;
    ctrl_view[B_SFLG] = sec_flag;
    ctrl_view[B_SIE]  = sie_q;
    ctrl_view[B_AFLG] = al_flag;
    ctrl_view[B_AIE]  = aie_q;
    ctrl_view[B_AEN]  = al_en_q;
    ctrl_view[B_RUN]  = run_q;
  end

  always_comb begin
    case (req_addr)
      A_CTRL:  rd_mux = ctrl_view;
      A_SEC:   rd_mux = sec_q;
      A_ALARM: rd_mux = alarm_q;
      A_REG:   rd_mux = regu_q;
      A_SCR:   rd_mux = scr_q;
      A_KEY:   rd_mux = {unlocked, 31'b0};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_cyc;
      if (rd_cyc)
        rsp_rdata <= rd_mux;
    end
  end

  assign irq = (sec_flag && sie_q) || (al_flag && aie_q);
endmodule

// File: rtl/rtc_sec_core_chk.sv
module rtc_sec_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        req_valid,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        wr_ok,
  input logic        wrdy,
  input logic        unlocked,
  input logic        sec_load,
  input logic        run,
  input logic [31:0] sec,
  input logic        sec_flag,
  input logic        al_flag,
  input logic        al_en
);
  a_r3_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !wrdy);
  a_r4_key_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !unlocked);
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sec_load) |=> $stable(sec));
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sec_load) |=> $stable(sec));
  a_r5_flag_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_flag) |-> $past(tick));
  a_r7_alarm_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al_flag) |-> $past(al_en));
  a_r11_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

bind rtc_sec_core rtc_sec_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
  .req_valid(req_valid), .req_write(req_write), .rsp_valid(rsp_valid),
  .wr_ok(wr_ok), .wrdy(wrdy), .unlocked(unlocked), .sec_load(sec_load),
  .run(run_q), .sec(sec_q), .sec_flag(sec_flag), .al_flag(al_flag),
  .al_en(al_en_q)
);

// File: tb/sim_rtc_sec_core.sv
module sim_rtc_sec_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_ce = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          div = 0;
  bit          done = 1'b0;

  rtc_sec_core u0 (
    .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .tick_1hz(tick_1hz),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slow-clock enable: one pulse every third cycle
  always @(negedge clk) begin
    div     = (div == 2) ? 0 : div + 1;
    slow_ce = (div == 0);
  end

  // monitor: compare each read response against the scoreboard
  always @(negedge clk) begin
    if (rsp_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected response: got %h expected none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_armed(input logic [7:0] a, input logic [31:0] d);
    bus_wr(8'h3C, 32'h0000_A55A);
    bus_wr(a, d);
    repeat (20) @(negedge clk);
  endtask

  task automatic tick;
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic chk_bit(input logic got, input logic exp, input string t);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", t, got, exp);
    end
  endtask

  task automatic drain;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_rd(8'h00, 32'h80, "R1 ctrl after reset");
    bus_rd(8'h04, 32'h0, "R1 sec after reset");
    chk_bit(irq, 1'b0, "R1 irq after reset");
    chk_bit(req_ready, 1'b1, "R11 req_ready");
    // R4 write without key ignored
    bus_wr(8'h04, 32'd5);
    bus_rd(8'h04, 32'h0, "R4 unkeyed write ignored");
    bus_wr(8'h3C, 32'h0000_A55A);
    bus_rd(8'h3C, 32'h8000_0000, "R4 key armed");
    bus_wr(8'h04, 32'd100);
    bus_rd(8'h00, 32'h00, "R3 write-ready low while busy");
    bus_rd(8'h3C, 32'h0, "R4 key cleared after write");
    bus_rd(8'h04, 32'd100, "R4 keyed write taken");
    // R3 write while busy ignored, key stays armed
    bus_wr(8'h3C, 32'h0000_A55A);
    bus_wr(8'h04, 32'd7);
    bus_rd(8'h04, 32'd100, "R3 busy write ignored");
    bus_rd(8'h3C, 32'h8000_0000, "R4 key kept on ignored write");
    repeat (20) @(negedge clk);
    bus_rd(8'h00, 32'h80, "R3 write-ready back");
    // R2/R5 tick with run off
    tick();
    bus_rd(8'h04, 32'd100, "R2 no count while stopped");
    bus_rd(8'h00, 32'hC0, "R5 second flag while stopped");
    // R6 writing 1 keeps flags
    wr_armed(8'h00, 32'h51);
    bus_rd(8'h00, 32'hC1, "R6 write one keeps flag");
    tick();
    bus_rd(8'h04, 32'd101, "R2 count while running");
    bus_rd(8'h04, 32'd101, "R11 repeat read stable");
    wr_armed(8'h00, 32'h01);
    bus_rd(8'h00, 32'h81, "R6 write zero clears flag");
    // R8 second interrupt
    wr_armed(8'h00, 32'h21);
    chk_bit(irq, 1'b0, "R8 irq idle");
    tick();
    chk_bit(irq, 1'b1, "R8 irq from second flag");
    // R7 alarm
    wr_armed(8'h08, 32'd104);
    bus_rd(8'h08, 32'd104, "R7 alarm readback");
    wr_armed(8'h00, 32'h0D);
    bus_rd(8'h00, 32'h8D, "R6 plain bits");
    chk_bit(irq, 1'b0, "R8 irq cleared");
    tick();
    drain();
    chk_bit(irq, 1'b0, "R8 masked second flag");
    tick();
    drain();
    chk_bit(irq, 1'b1, "R8 irq from alarm");
    bus_rd(8'h00, 32'hDD, "R7 alarm flag set");
    wr_armed(8'h08, 32'd105);
    wr_armed(8'h00, 32'h01);
    chk_bit(irq, 1'b0, "R8 irq after clear");
    tick();
    drain();
    bus_rd(8'h04, 32'd105, "R7 count reached alarm");
    bus_rd(8'h00, 32'hC1, "R7 no flag when disabled");
    // R10, R12
    wr_armed(8'h0C, 32'hCAFE_0001);
    bus_rd(8'h0C, 32'hCAFE_0001, "R10 regulator readback");
    bus_rd(8'h10, 32'h0, "R12 unmapped read");
    // R9 scratch across reset
    wr_armed(8'h34, 32'h1234_5678);
    drain();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_rd(8'h34, 32'h1234_5678, "R9 scratch kept");
    bus_rd(8'h00, 32'h80, "R1 ctrl after second reset");
    bus_rd(8'h04, 32'h0, "R1 sec after second reset");
    bus_rd(8'h0C, 32'h0, "R1 regulator after reset");
    drain();
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R11 missing responses: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule